// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps the per-vector state of a 256-vector interrupt controller. It holds three bit arrays: requests waiting for service (pending), requests the core has taken and not yet retired (in service), and the trigger kind each pending request came with. It also holds a task-priority value, from which it derives a registered processor-priority value. From this state it presents the one vector the core may take now.

Requests come in on an accept port. The core takes the offered vector with a one-cycle acknowledge strobe and retires it with an end-of-interrupt write. When the retired vector was level-triggered, the block emits a one-cycle broadcast with that vector number so the originating source can re-arm. Software can raise or lower the task priority through a full 8-bit write or a 4-bit class write. Doing so holds off every vector whose priority class does not exceed it.

Top module: `vec_prio_tracker`

## Requirements
- R1: `dlv_vec` is the highest-numbered pending vector. The search runs over the pending array as 8 words of 32 bits, from the top word downward.
- R2: `ppr_out` is a register recomputed every cycle. It equals the 8-bit task priority when bits 7:4 of the task priority are at least bits 7:4 of the highest in-service vector. Otherwise it equals that vector with bits 3:0 zeroed; an empty in-service array counts as vector 0. A change of task priority or in-service state shows on `ppr_out` one cycle after the state register changes.
- R3: `dlv_valid` is high only when (`dlv_vec` AND 0xF0) is strictly greater than `ppr_out`. Vectors 0x00 to 0x0F are therefore never offered while `ppr_out` is 0.
- R4: `dlv_valid` is low whenever `hw_en` or `sw_en` is low, without changing the pending array.
- R5: An `ack` while `dlv_valid` is high sets the in-service bit of `dlv_vec` and clears its pending bit. An `ack` while `dlv_valid` is low does nothing.
- R6: An `eoi_wr` clears the highest in-service bit. When that vector's trigger bit is set, the write also clears the trigger bit and, one cycle later, raises `eoi_bc_valid` for one cycle with `eoi_bc_vec` equal to the vector. With no in-service bit set, the write has no effect.
- R7: An accept sets the pending bit of `acc_vec` and records `acc_level` (1 = level, 0 = edge) as its trigger bit. `acc_taken` is high only when the pending bit was not already set. A level request that finds its pending bit already set changes nothing.
- R8: While `hw_en` and `sw_en` are not both high, accept requests are discarded and `acc_taken` is low.
- R9: A `tpr_wr` keeps only bits 7:4… more precisely bits 7:0 of `tpr_data`. A `tpr4_wr` loads `tpr4_data` into bits 7:4 with bits 3:0 zero. When both write in the same cycle, `tpr_wr` wins.
- R10: After reset, all three arrays and the task priority are clear: `dlv_valid` is 0, `ppr_out` is 0 and `eoi_bc_valid` is 0.
- R11: When an accept and an acknowledge name the same vector in one cycle, the acknowledge applies first. The accept then finds the pending bit clear, is taken, sets the pending bit again and records its trigger kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| acc_valid | input | 1 | Accept request strobe |
| acc_vec | input | 8 | Vector of the accept request |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| acc_taken | output | 1 | Request newly made pending (same cycle) |
| ack | input | 1 | Core takes the offered vector |
| eoi_wr | input | 1 | End-of-interrupt write |
| tpr_wr | input | 1 | Full task-priority write |
| tpr_data | input | BUS_W | Task-priority write data, bits 7:0 kept |
| tpr4_wr | input | 1 | 4-bit class write |
| tpr4_data | input | 4 | Class value, loaded into bits 7:4 |
| dlv_valid | output | 1 | A vector may be taken now |
| dlv_vec | output | 8 | Vector offered to the core |
| ppr_out | output | 8 | Processor priority |
| eoi_bc_valid | output | 1 | Level-triggered retirement broadcast |
| eoi_bc_vec | output | 8 | Vector carried by the broadcast |

## Verification
The checks assume the core acknowledges only a vector it sees offered. They also assume that, after an acknowledge, it waits for the registered priority to settle before taking the next vector, since a second acknowledge one cycle later could take a same-class vector against stale priority. The stimulus keeps every strobe one cycle wide and leaves at least two idle cycles after each acknowledge, end-of-interrupt or priority write. It also starts driving only after the internal reset synchronizer has released, so no write is lost in the release window.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLS_W   = 4;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [NUM_VEC-1:0] vec_map_t;

  // Priority class of a vector, kept in place (low nibble cleared).
  function automatic vec_t class_of(vec_t v);
    return {v[VEC_W-1 -: CLS_W], {(VEC_W-CLS_W){1'b0}}};
  endfunction
endpackage

// File: rtl/vpt_rst_sync.sv
module vpt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vpt_find_top.sv
module vpt_find_top #(
  parameter int NUM    = 256,
  parameter int WORD_W = 32
) (
  input  logic [NUM-1:0]         bits,
  output logic                   found,
  output logic [$clog2(NUM)-1:0] idx
);
  localparam int NW  = NUM / WORD_W;
  localparam int WIW = $clog2(WORD_W);
  localparam int WSW = $clog2(NW);

  logic [NW-1:0]  word_any;
  logic [WIW-1:0] word_pos [NW];
  logic [WSW-1:0] sel;

  // Per-word reduction and in-word top-bit position.
  for (genvar w = 0; w < NW; w++) begin : g_word
    assign word_any[w] = |bits[w*WORD_W +: WORD_W];
    always_comb begin
      word_pos[w] = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (bits[w*WORD_W + b]) word_pos[w] = WIW'(b);
      end
    end
  end

  // Highest non-empty word wins.
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int w = 0; w < NW; w++) begin
      if (word_any[w]) begin
        found = 1'b1;
        sel   = WSW'(w);
      end
    end
  end

  assign idx = {sel, word_pos[sel]};
endmodule

// File: rtl/vpt_ppr_calc.sv
module vpt_ppr_calc
  import vpt_pkg::*;
(
  input  vec_t tpr,
  input  logic isr_found,
  input  vec_t isr_top,
  output vec_t ppr
);
  vec_t isr_cls;

  always_comb begin
    isr_cls = isr_found ? class_of(isr_top) : '0;
    if (class_of(tpr) >= isr_cls) ppr = tpr;
    else                          ppr = isr_cls;
  end
endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker
  import vpt_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic             sw_en,
  input  logic             acc_valid,
  input  logic [7:0]       acc_vec,
  input  logic             acc_level,
  output logic             acc_taken,
  input  logic             ack,
  input  logic             eoi_wr,
  input  logic             tpr_wr,
  input  logic [BUS_W-1:0] tpr_data,
  input  logic             tpr4_wr,
  input  logic [3:0]       tpr4_data,
  output logic             dlv_valid,
  output logic [7:0]       dlv_vec,
  output logic [7:0]       ppr_out,
  output logic             eoi_bc_valid,
  output logic [7:0]       eoi_bc_vec
);
  localparam vec_map_t ONE = vec_map_t'(1);

  logic rst_q_n;
  vpt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  // State registers and next values
  vec_map_t irr_q, isr_q, tmr_q;
  vec_map_t irr_n, isr_n, tmr_n;
  vec_t     tpr_q, tpr_n;
  vec_t     ppr_q, ppr_n;
  logic     bc_v_q, bc_v_n;
  vec_t     bc_vec_q, bc_vec_n;
  logic     map_en, tpr_en, bc_vec_en;

  logic irr_found, isr_found;
  vec_t irr_top, isr_top;
  logic enabled;
  logic ack_fire, eoi_fire, bc_hit;
  logic acc_en, acc_hit, acc_write;
  vec_map_t ack_mask, eoi_mask, acc_mask, irr_mid, tmr_mid;
  logic unused_tpr_hi;

  assign unused_tpr_hi = ^tpr_data[BUS_W-1:VEC_W];

  vpt_find_top #(.NUM(NUM_VEC), .WORD_W(WORD_W)) u_irr_top (
    .bits(irr_q), .found(irr_found), .idx(irr_top));
  vpt_find_top #(.NUM(NUM_VEC), .WORD_W(WORD_W)) u_isr_top (
    .bits(isr_q), .found(isr_found), .idx(isr_top));
  vpt_ppr_calc u_ppr (
    .tpr(tpr_q), .isr_found(isr_found), .isr_top(isr_top), .ppr(ppr_n));

  // Offer logic
  assign enabled   = hw_en & sw_en;
  assign dlv_vec   = irr_top;
  assign dlv_valid = enabled & irr_found & (class_of(irr_top) > ppr_q);

  // Acknowledge is applied before accept (same-vector ordering).
  assign ack_fire  = ack & dlv_valid;
  assign ack_mask  = ack_fire ? (ONE << irr_top) : '0;
  assign irr_mid   = irr_q & ~ack_mask;

  assign acc_en    = acc_valid & enabled;
  assign acc_hit   = irr_mid[acc_vec];
  assign acc_taken = acc_en & ~acc_hit;
  assign acc_write = acc_en & ~(acc_level & acc_hit);
  assign acc_mask  = acc_write ? (ONE << acc_vec) : '0;

  // End of interrupt retires the highest in-service vector.
  assign eoi_fire  = eoi_wr & isr_found;
  assign eoi_mask  = eoi_fire ? (ONE << isr_top) : '0;
  assign bc_hit    = eoi_fire & tmr_q[isr_top];
  assign tmr_mid   = bc_hit ? (tmr_q & ~eoi_mask) : tmr_q;

  always_comb begin
    irr_n = irr_mid | acc_mask;
    isr_n = (isr_q & ~eoi_mask) | ack_mask;
    if (acc_write && acc_level) tmr_n = tmr_mid | acc_mask;
    else                        tmr_n = tmr_mid & ~acc_mask;
    map_en = ack_fire | eoi_fire | acc_write;

    tpr_en = tpr_wr | tpr4_wr;
    if (tpr_wr) tpr_n = tpr_data[VEC_W-1:0];
    else        tpr_n = {tpr4_data, {(VEC_W-CLS_W){1'b0}}};

    bc_v_n    = bc_hit;
    bc_vec_n  = isr_top;
    bc_vec_en = bc_hit;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else if (map_en) begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    tpr_q <= '0;
    else if (tpr_en) tpr_q <= tpr_n;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ppr_q <= '0;
    else          ppr_q <= ppr_n;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      bc_v_q   <= 1'b0;
      bc_vec_q <= '0;
    end else begin
      bc_v_q <= bc_v_n;
      if (bc_vec_en) bc_vec_q <= bc_vec_n;
    end
  end

  assign ppr_out      = ppr_q;
  assign eoi_bc_valid = bc_v_q;
  assign eoi_bc_vec   = bc_vec_q;
endmodule

// File: rtl/vec_prio_tracker_chk.sv
module vec_prio_tracker_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             hw_en,
  input logic             sw_en,
  input logic             acc_valid,
  input logic             acc_taken,
  input logic             eoi_wr,
  input logic             tpr_wr,
  input logic [BUS_W-1:0] tpr_data,
  input logic             tpr4_wr,
  input logic             dlv_valid,
  input logic [7:0]       dlv_vec,
  input logic [7:0]       ppr_out,
  input logic             eoi_bc_valid
);
  // R3: an offered vector's class is above processor priority
  p_dlv_class_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    dlv_valid |-> ({dlv_vec[7:4], 4'h0} > ppr_out));

  // R4: no offer while disabled
  p_dis_no_dlv_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(hw_en && sw_en) |-> !dlv_valid);

  // R8: no request taken while disabled
  p_dis_drop_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_valid && !(hw_en && sw_en)) |-> !acc_taken);

  // R6: a broadcast only follows an end-of-interrupt write
  p_bc_after_eoi_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    eoi_bc_valid |-> $past(eoi_wr));

  // R2: processor priority never falls below a settled task priority
  p_tpr_floor_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(tpr_wr, 2) && !$past(tpr_wr) && !$past(tpr4_wr))
      |-> (ppr_out[7:4] >= $past(tpr_data[7:4], 2)));
endmodule

bind vec_prio_tracker vec_prio_tracker_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .hw_en(hw_en), .sw_en(sw_en),
  .acc_valid(acc_valid), .acc_taken(acc_taken), .eoi_wr(eoi_wr),
  .tpr_wr(tpr_wr), .tpr_data(tpr_data), .tpr4_wr(tpr4_wr),
  .dlv_valid(dlv_valid), .dlv_vec(dlv_vec), .ppr_out(ppr_out),
  .eoi_bc_valid(eoi_bc_valid));

// File: tb/vec_prio_tracker_test.sv
module vec_prio_tracker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hw_en, sw_en;
  logic        acc_valid, acc_level, acc_taken;
  logic [7:0]  acc_vec;
  logic        ack, eoi_wr, tpr_wr, tpr4_wr;
  logic [31:0] tpr_data;
  logic [3:0]  tpr4_data;
  logic        dlv_valid, eoi_bc_valid;
  logic [7:0]  dlv_vec, ppr_out, eoi_bc_vec;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_prio_tracker uut (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
    .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
    .acc_taken(acc_taken), .ack(ack), .eoi_wr(eoi_wr),
    .tpr_wr(tpr_wr), .tpr_data(tpr_data), .tpr4_wr(tpr4_wr),
    .tpr4_data(tpr4_data), .dlv_valid(dlv_valid), .dlv_vec(dlv_vec),
    .ppr_out(ppr_out), .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vec(eoi_bc_vec));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic accept(logic [7:0] v, logic lvl, int exp_taken, string tag);
    acc_valid = 1'b1; acc_vec = v; acc_level = lvl;
    #1 chk(tag, int'(acc_taken), exp_taken);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    step(1);
  endtask

  task automatic eoi(bit exp_bc, logic [7:0] v);
    if (exp_bc) exp_q.push_back(int'(v));
    eoi_wr = 1'b1;
    @(negedge clk);
    eoi_wr = 1'b0;
    step(1);
  endtask

  task automatic tpr_full(logic [31:0] d);
    tpr_wr = 1'b1; tpr_data = d;
    @(negedge clk);
    tpr_wr = 1'b0;
    step(1);
  endtask

  task automatic tpr_class(logic [3:0] d);
    tpr4_wr = 1'b1; tpr4_data = d;
    @(negedge clk);
    tpr4_wr = 1'b0;
    step(1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Scoreboard monitor for the retirement broadcast (R6)
  always @(negedge clk) begin
    if (eoi_bc_valid === 1'b1) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 broadcast: actual 0x%0h expected none", eoi_bc_vec);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(eoi_bc_vec) != e) begin
          n_fail++;
          $display("FAIL R6 broadcast vector: actual 0x%0h expected 0x%0h", eoi_bc_vec, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; hw_en = 1'b1; sw_en = 1'b1;
    acc_valid = 1'b0; acc_vec = '0; acc_level = 1'b0;
    ack = 1'b0; eoi_wr = 1'b0; tpr_wr = 1'b0; tpr_data = '0;
    tpr4_wr = 1'b0; tpr4_data = '0;
    step(3);
    rst_n = 1'b1;
    step(3);

    chk("R10 dlv_valid", int'(dlv_valid), 0);
    chk("R10 ppr", int'(ppr_out), 0);
    chk("R10 bc", int'(eoi_bc_valid), 0);

    accept(8'h45, 1'b0, 1, "R7 new edge taken");
    chk("R1 dlv_valid", int'(dlv_valid), 1);
    chk("R1 single", int'(dlv_vec), 'h45);
    accept(8'h80, 1'b1, 1, "R7 new level taken");
    chk("R1 highest", int'(dlv_vec), 'h80);
    accept(8'h80, 1'b1, 0, "R7 level repeat dropped");

    tpr_full(32'hABCD_0190);
    chk("R9 low byte kept", int'(ppr_out), 'h90);
    chk("R3 class held off", int'(dlv_valid), 0);
    tpr_full(32'h80);
    chk("R3 equal class blocks", int'(dlv_valid), 0);
    tpr_full(32'h7F);
    chk("R3 strictly above", int'(dlv_valid), 1);
    chk("R3 vector", int'(dlv_vec), 'h80);
    tpr_full(32'h0);

    pulse_ack();
    chk("R2 ppr from isr", int'(ppr_out), 'h80);
    chk("R5 lower class waits", int'(dlv_valid), 0);
    tpr_class(4'h9);
    chk("R9 class write", int'(ppr_out), 'h90);
    tpr_class(4'h3);
    chk("R2 isr above tpr", int'(ppr_out), 'h80);
    tpr_full(32'h0);

    eoi(1'b1, 8'h80);
    chk("R6 ppr after eoi", int'(ppr_out), 0);
    chk("R6 next offer", int'(dlv_vec), 'h45);
    pulse_ack();
    chk("R5 ppr after ack", int'(ppr_out), 'h40);
    eoi(1'b0, 8'h00);
    chk("R5 pending cleared", int'(dlv_valid), 0);

    tpr_full(32'h25);
    eoi(1'b0, 8'h00);
    chk("R6 empty eoi no effect", int'(ppr_out), 'h25);
    tpr_full(32'h0);

    sw_en = 1'b0;
    accept(8'h60, 1'b0, 0, "R8 disabled drop");
    sw_en = 1'b1;
    step(1);
    chk("R8 nothing pending", int'(dlv_valid), 0);
    accept(8'h60, 1'b0, 1, "R7 taken");
    hw_en = 1'b0;
    #1 chk("R4 hw off hides", int'(dlv_valid), 0);
    @(negedge clk);
    hw_en = 1'b1;
    #1 chk("R4 pending kept", int'(dlv_vec), 'h60);
    chk("R4 offer back", int'(dlv_valid), 1);
    @(negedge clk);

    ack = 1'b1; acc_valid = 1'b1; acc_vec = 8'h60; acc_level = 1'b1;
    #1 chk("R11 accept after ack taken", int'(acc_taken), 1);
    @(negedge clk);
    ack = 1'b0; acc_valid = 1'b0;
    step(1);
    chk("R11 ppr", int'(ppr_out), 'h60);
    eoi(1'b1, 8'h60);
    chk("R11 re-pending offered", int'(dlv_valid), 1);
    chk("R11 vector", int'(dlv_vec), 'h60);
    pulse_ack();
    eoi(1'b0, 8'h00);

    accept(8'h05, 1'b0, 1, "R7 low vector taken");
    chk("R3 class zero never offered", int'(dlv_valid), 0);
    accept(8'hFF, 1'b0, 1, "R7 top vector");
    accept(8'h10, 1'b0, 1, "R7 class one");
    chk("R1 top word", int'(dlv_vec), 'hFF);
    pulse_ack();
    chk("R3 top class blocks", int'(dlv_valid), 0);
    eoi(1'b0, 8'h00);
    chk("R1 bottom word", int'(dlv_vec), 'h10);
    step(2);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R6 missing broadcasts: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule